// File: doc/BRIEF.md
# MDIO Management Responder

This block is the PHY end of a two-wire serial management link. It runs on a fast system clock and oversamples the management clock and the data line that a host drives. It finds rising edges of the management clock by comparing the sampled level with a registered copy. On each rising edge it shifts one data bit into a sync window. A run of ones as long as the window marks the frame boundary. From that point it counts edges to find the header and then the data phase.

After the 16 header bits it checks the start code, the opcode and the turnaround pattern. It latches the register and PHY address fields. A read frame returns a 16-bit value from a 32-entry register file, most significant bit first, one bit per edge. In that file, entries 2 and 3 hold identifier words and every other entry reads as zero. A write frame captures the data word and reports it with a one-cycle strobe. The register file itself does not change. Every PHY address is answered.

Top module: `mdio_responder`

## Requirements
- R1: During and right after reset, `rd_dat_o` and `wr_valid_o` are 0.
- R2: The bit shifted in on a management clock rising edge is 1 only when both `host_dat_i` and `host_oe_i` are 1. Ones sent with the output enable low do not count toward sync.
- R3: Sync needs at least 32 consecutive shifted ones. A frame after only 31 ones gets no response.
- R4: A frame whose 16 header bits, in order of arrival, are start `01`, opcode `10`, a 5-bit PHY address, a 5-bit register address and a turnaround with its last bit 0 is a read. Over the next 16 rising edges, `rd_dat_o` takes the addressed value MSB first, and each bit appears in the system cycle after its edge.
- R5: Register 2 reads 0x0022, register 3 reads 0x161a, and all other registers read 0x0000.
- R6: A header with start `01`, opcode `01` and turnaround `10` is a write. In the cycle after the 16th data edge, `wr_valid_o` pulses for one cycle with the PHY address, the register address and the 16 data bits (first bit arriving = bit 15).
- R7: A write whose turnaround is not `10`, or a read whose last turnaround bit is 1, gives no response. A read turnaround of `10` is accepted.
- R8: A start code other than `01`, or an opcode of `00` or `11`, gives no response.
- R9: The PHY address is not compared. Any value, including 0 and 31, gets a response.
- R10: `rd_dat_o` changes only in the cycle after a management clock rising edge. It returns to 0 on the first edge after a read frame ends.
- R11: A preamble longer than 32 ones is accepted. The frame is timed from the last all-ones window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_clk_i | input | 1 | Management clock level, sampled on `clk` |
| host_dat_i | input | 1 | Data bit driven by the host |
| host_oe_i | input | 1 | Host output enable for the data line |
| rd_dat_o | output | 1 | Read data returned to the host |
| wr_valid_o | output | 1 | One-cycle strobe for a captured write |
| wr_phy_o | output | 5 | PHY address of the captured write |
| wr_reg_o | output | 5 | Register address of the captured write |
| wr_data_o | output | 16 | Data word of the captured write |

## Verification
Reads are sent to the two identifier registers and to zero-valued entries. A mix of PHY addresses shows that neither the address field nor the bit order is taken from a fixed position by accident. Writes carry a checkered word and an all-ones word, which exposes bit-order or off-by-one capture. Each field that should reject a frame is corrupted in turn: start, opcode, each turnaround variant, a 31-bit preamble, and a preamble sent with the enable low. Each of these tells a decode fault apart from a sync fault. A longer preamble and a recovery read after the rejected frames show that the edge count restarts cleanly from the last full sync window.

// File: rtl/mdio_responder.sv
module mdio_responder #(
  parameter logic [15:0] ID_HI = 16'h0022,
  parameter logic [15:0] ID_LO = 16'h161a,
  parameter int          WIN   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mgmt_clk_i,
  input  logic        host_dat_i,
  input  logic        host_oe_i,
  output logic        rd_dat_o,
  output logic        wr_valid_o,
  output logic [4:0]  wr_phy_o,
  output logic [4:0]  wr_reg_o,
  output logic [15:0] wr_data_o
);
  localparam int FRAME = 32;
  localparam int HDR   = 16;
  localparam int CW    = $clog2(FRAME + 1);

  typedef enum logic [1:0] {IDLE, RD, WR} st_t;

  logic           mdc_q;
  logic [WIN-1:0] sh;
  logic [CW-1:0]  cnt;
  st_t            st, st_d;
  logic [15:0]    dout;
  logic [4:0]     phy, ra;

  wire            rise     = mgmt_clk_i & ~mdc_q;
  wire [WIN-1:0]  sh_n     = {sh[WIN-2:0], host_dat_i & host_oe_i};
  wire [CW-1:0]   cnt_v    = (&sh_n) ? CW'(FRAME) : cnt;
  wire            at_hdr   = (cnt_v == CW'(HDR));
  wire            start_ok = (sh_n[15:14] == 2'b01);
  wire            rd_hdr   = start_ok && (sh_n[13:12] == 2'b10) && !sh_n[0];
  wire            wr_hdr   = start_ok && (sh_n[13:12] == 2'b01) && (sh_n[1:0] == 2'b10);

  function automatic logic [15:0] regfile(input logic [4:0] a);
    case (a)
      5'd2:    return ID_HI;
      5'd3:    return ID_LO;
      default: return 16'h0000;
    endcase
  endfunction

  always_comb begin
    st_d = st;
    if (at_hdr) st_d = rd_hdr ? RD : (wr_hdr ? WR : IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_q      <= 1'b0;
      sh         <= '0;
      cnt        <= '0;
      st         <= IDLE;
      dout       <= '0;
      phy        <= '0;
      ra         <= '0;
      rd_dat_o   <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_phy_o   <= '0;
      wr_reg_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      mdc_q      <= mgmt_clk_i;
      wr_valid_o <= 1'b0;
      if (rise) begin
        sh  <= sh_n;
        cnt <= (cnt_v != '0) ? cnt_v - 1'b1 : '0;
        st  <= st_d;
        if (at_hdr) begin
          phy  <= sh_n[11:7];
          ra   <= sh_n[6:2];
          dout <= regfile(sh_n[6:2]);
        end
        if (cnt_v < CW'(HDR) && st_d == RD) begin
          rd_dat_o <= dout[15];
          dout     <= {dout[14:0], 1'b0};
        end else if (st_d == IDLE) begin
          rd_dat_o <= 1'b0;
        end
        if (cnt_v == '0 && st_d != IDLE) begin
          st <= IDLE;
          if (st_d == WR) begin
            wr_valid_o <= 1'b1;
            wr_phy_o   <= phy;
            wr_reg_o   <= ra;
            wr_data_o  <= sh_n[15:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_responder_chk.sv
module mdio_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic mgmt_clk_i,
  input logic rd_dat_o,
  input logic wr_valid_o
);
  logic prev;
  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= mgmt_clk_i;
  end

  assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);

  assert_wr_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid_o) |-> ($past(mgmt_clk_i) && !$past(prev)));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mgmt_clk_i && !prev) |=> $stable(rd_dat_o));

  assert_no_rd_with_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid_o && rd_dat_o));
endmodule

bind mdio_responder mdio_responder_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .mgmt_clk_i(mgmt_clk_i),
  .rd_dat_o(rd_dat_o),
  .wr_valid_o(wr_valid_o)
);

// File: tb/sim_mdio_responder.sv
module sim_mdio_responder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, mdc = 1'b0, dat = 1'b0, oe = 1'b0;
  logic        rd_dat, wr_valid;
  logic [4:0]  wr_phy, wr_reg;
  logic [15:0] wr_data;

  int    errors = 0, checks = 0;
  bit    run = 0;
  logic  exp_mdi = 1'b0, exp_wr = 1'b0;
  logic [4:0]  exp_phy = '0, exp_reg = '0;
  logic [15:0] exp_data = '0;
  string req = "R1";

  mdio_responder u0 (
    .clk(clk), .rst_n(rst_n), .mgmt_clk_i(mdc), .host_dat_i(dat), .host_oe_i(oe),
    .rd_dat_o(rd_dat), .wr_valid_o(wr_valid), .wr_phy_o(wr_phy),
    .wr_reg_o(wr_reg), .wr_data_o(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference comparison on every clock, away from the active edge
  always @(negedge clk) if (run) begin
    checks++;
    if (rd_dat !== exp_mdi) begin
      errors++;
      $display("FAIL %s rd_dat_o=%b expected %b at %0t", req, rd_dat, exp_mdi, $time);
    end
    checks++;
    if (wr_valid !== exp_wr) begin
      errors++;
      $display("FAIL %s wr_valid_o=%b expected %b at %0t", req, wr_valid, exp_wr, $time);
    end
    if (exp_wr) begin
      checks++;
      if ({wr_phy, wr_reg, wr_data} !== {exp_phy, exp_reg, exp_data}) begin
        errors++;
        $display("FAIL %s write phy=%h reg=%h data=%h expected phy=%h reg=%h data=%h",
                 req, wr_phy, wr_reg, wr_data, exp_phy, exp_reg, exp_data);
      end
    end
  end

  function automatic logic [15:0] regval(input logic [4:0] a);
    if (a == 5'd2) return 16'h0022;
    if (a == 5'd3) return 16'h161a;
    return 16'h0000;
  endfunction

  task automatic edge_bit(input logic b, input logic e, input logic em, input logic ew);
    @(negedge clk); dat = b; oe = e; mdc = 1'b1;
    @(posedge clk); exp_mdi = em; exp_wr = ew;
    @(posedge clk); exp_wr = 1'b0;
    @(negedge clk); mdc = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame(input int npre, input bit pre_oe, input logic [1:0] stc,
                       input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                       input logic [1:0] ta, input logic [15:0] d, input string r);
    logic [15:0] hdr, rv;
    bit sync, rd_ok, wr_ok;
    hdr   = {stc, op, phy, ra, ta};
    rv    = regval(ra);
    sync  = pre_oe && (npre >= 32);
    rd_ok = sync && stc == 2'b01 && op == 2'b10 && ta[0] == 1'b0;
    wr_ok = sync && stc == 2'b01 && op == 2'b01 && ta == 2'b10;
    req = "R10";
    edge_bit(1'b0, 1'b0, 1'b0, 1'b0);  // idle edge: read data back to 0 (R10)
    req = r;
    for (int i = 0; i < npre; i++) edge_bit(1'b1, pre_oe, 1'b0, 1'b0);
    for (int i = 15; i >= 0; i--) edge_bit(hdr[i], 1'b1, 1'b0, 1'b0);
    exp_phy = phy; exp_reg = ra; exp_data = d;
    for (int k = 0; k < 16; k++)
      edge_bit((op == 2'b10) ? 1'b0 : d[15-k], (op != 2'b10),
               rd_ok ? rv[15-k] : 1'b0, wr_ok && (k == 15));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rd_dat !== 1'b0 || wr_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset rd=%b wr=%b expected 0 0", rd_dat, wr_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rd_dat !== 1'b0 || wr_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset rd=%b wr=%b expected 0 0", rd_dat, wr_valid);
    end
    run = 1;
    frame(32, 1, 2'b01, 2'b10, 5'd1,  5'd2,  2'b00, 16'h0,    "R4");  // read ID_HI
    frame(32, 1, 2'b01, 2'b10, 5'd31, 5'd3,  2'b00, 16'h0,    "R5");  // read ID_LO, R9 phy 31
    frame(34, 1, 2'b01, 2'b10, 5'd0,  5'd0,  2'b00, 16'h0,    "R5");  // zero entry, R9 phy 0
    frame(32, 1, 2'b01, 2'b10, 5'd6,  5'd31, 2'b00, 16'h0,    "R5");
    frame(40, 1, 2'b01, 2'b10, 5'd7,  5'd3,  2'b10, 16'h0,    "R11"); // long preamble, ta 10 read ok (R7)
    frame(32, 1, 2'b01, 2'b01, 5'd9,  5'd4,  2'b10, 16'hA5C3, "R6");
    frame(33, 1, 2'b01, 2'b01, 5'd0,  5'd31, 2'b10, 16'hFFFF, "R9");
    frame(32, 1, 2'b01, 2'b01, 5'd3,  5'd3,  2'b11, 16'h1234, "R7");
    frame(32, 1, 2'b01, 2'b01, 5'd3,  5'd3,  2'b00, 16'h1234, "R7");
    frame(32, 1, 2'b01, 2'b10, 5'd3,  5'd2,  2'b01, 16'h0,    "R7");
    frame(32, 1, 2'b00, 2'b10, 5'd3,  5'd2,  2'b00, 16'h0,    "R8");
    frame(32, 1, 2'b01, 2'b11, 5'd3,  5'd2,  2'b10, 16'h00FF, "R8");
    frame(32, 1, 2'b01, 2'b00, 5'd3,  5'd3,  2'b10, 16'hF00F, "R8");
    frame(31, 1, 2'b01, 2'b10, 5'd3,  5'd2,  2'b00, 16'h0,    "R3");
    frame(31, 1, 2'b01, 2'b01, 5'd3,  5'd2,  2'b10, 16'h5555, "R3");
    frame(40, 0, 2'b01, 2'b10, 5'd3,  5'd2,  2'b00, 16'h0,    "R2");
    frame(32, 1, 2'b01, 2'b10, 5'd4,  5'd3,  2'b00, 16'h0,    "R4");  // recovery read
    req = "R10";
    edge_bit(1'b0, 1'b0, 1'b0, 1'b0);
    edge_bit(1'b0, 1'b0, 1'b0, 1'b0);
    run = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired in %s: actual hung expected done", req);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule